// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block watches 32 general-purpose input pins and turns their activity into interrupt requests. Each pin has a 4-bit sense field that chooses what counts as an event: a rising edge, a falling edge, both edges, a high level or a low level. One bit of that field routes the pin around the input synchronizer for earlier detection. An event is accepted only while the pin's acceptance bit is set. It then drives a small per-pin latch state machine into its pending state. Software masks or unmasks each pin through two write-one registers, one that sets and one that clears. It acknowledges an event by writing one to the pin's bit in the clear register.

Software reads two kinds of status. The masked view is pending AND enabled for all pins. The raw view is split into a lower and an upper half. Two request lines leave the block: one for pins 0 to 15 and one for pins 16 to 31. Register access is a plain single-cycle port. A write lands on the clock edge where the write enable is high. Read data is a combinational function of the address and the current register state.

Each pin's latch has two states. `LATCH_IDLE` moves to `LATCH_PEND` on the transition *event*. `LATCH_PEND` moves back to `LATCH_IDLE` on the transition *clear without event*. In every other case the latch keeps its state.

Top module: `gsi_irq_sense`

## Requirements
- R1: Pin n's sense field is bits [4*(n&7)+3 : 4*(n&7)] of the sense register at byte offset 0x20 + 4*(n>>3). The four sense registers, 0x20 to 0x2C, read back what was written.
- R2: The low three bits of a sense field select the mode: 0 rising edge, 1 falling edge, 2 high level, 3 low level, 4 either edge. Codes 5 to 7 never produce an event.
- R3: Writing a one to a bit at offset 0x04 unmasks that pin. Writing a one to a bit at offset 0x08 masks it. Zero bits in either write leave the mask unchanged.
- R4: Writing a one to a bit at offset 0x10 returns that pin's latch to idle. Zero bits leave the latch unchanged.
- R5: The acceptance register at offset 0x14 reads back what was written. While a pin's acceptance bit is 0, that pin's latch cannot enter the pending state.
- R6: Offset 0x00 reads the pending bits ANDed with the enable mask, one bit per pin.
- R7: Offset 0x50 returns the raw pending bits of pins 0 to 15 in bits [15:0]. Offset 0x54 returns pins 16 to 31 in bits [15:0]. Bits [31:16] of both reads are zero.
- R8: Suppose a pin change is first sampled on clock edge k. With sense bit 3 at 0 (synchronized), the pending bit becomes visible after edge k+2. With bit 3 at 1 (bypass), it becomes visible after edge k+1.
- R9: For a level mode, the pending bit stays set while the level remains active, even if a clear is written.
- R10: For an edge mode, a cleared pending bit stays clear while the pin holds steady. Only a new qualifying edge sets it again.
- R11: `irq_lo_o` is high exactly when any masked-status bit 0 to 15 is set. `irq_hi_o` is high exactly when any of bits 16 to 31 is set.
- R12: After reset, all pins are masked, no bit is pending, acceptance is all zero, every sense field is zero, and both request lines are low.
- R13: If a clear and an event for the same pin fall in the same cycle, the event wins and the pin remains pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Pin levels to be watched |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe, applied at the clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_lo_o | output | 1 | Request for pins 0 to 15 |
| irq_hi_o | output | 1 | Request for pins 16 to 31 |

## Verification
The bench builds the block with its default parameters: 32 pins, 32-bit data, 8-bit address and a two-stage synchronizer. With those values, pins in all four sense registers and both request halves can be reached. The value two for the synchronizer depth lets the bench count the exact one-cycle gap between synchronized and bypass detection. A table then walks every sense code, including a reserved one and the bypass variants, across pins in each packed register. The directed tests cover mask set and clear with zero bits, acceptance gating, and level sensing that outlasts a clear.

// File: rtl/gsi_pkg.sv
package gsi_pkg;

    typedef enum logic [2:0] {
        SNS_RISE = 3'd0,
        SNS_FALL = 3'd1,
        SNS_HIGH = 3'd2,
        SNS_LOW  = 3'd3,
        SNS_BOTH = 3'd4
    } sense_code_t;

    typedef enum logic {
        LATCH_IDLE = 1'b0,
        LATCH_PEND = 1'b1
    } latch_state_t;

    localparam int OFF_MASKED = 'h00;
    localparam int OFF_EN_SET = 'h04;
    localparam int OFF_EN_CLR = 'h08;
    localparam int OFF_ACK    = 'h10;
    localparam int OFF_ACCEPT = 'h14;
    localparam int OFF_SENSE0 = 'h20;
    localparam int OFF_RAW_LO = 'h50;
    localparam int OFF_RAW_HI = 'h54;

    localparam int FIELD_W = 4;

endpackage

// File: rtl/gsi_sync.sv
module gsi_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] first_o,
    output logic [W-1:0] last_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= d_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign first_o = chain_q[0];
    assign last_o  = chain_q[STAGES-1];

endmodule

// File: rtl/gsi_pin_det.sv
module gsi_pin_det
    import gsi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               early_i,
    input  logic               late_i,
    input  logic [FIELD_W-1:0] mode_i,
    input  logic               accept_i,
    input  logic               ack_i,
    output logic               evt_o,
    output logic               pend_o
);

    latch_state_t state_q, state_d;
    logic         src;
    logic         prev_q;
    logic         hit;

    assign src = mode_i[FIELD_W-1] ? early_i : late_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src;
    end

    always_comb begin
        case (mode_i[2:0])
            SNS_RISE: hit = src & ~prev_q;
            SNS_FALL: hit = ~src & prev_q;
            SNS_HIGH: hit = src;
            SNS_LOW:  hit = ~src;
            SNS_BOTH: hit = src ^ prev_q;
            default:  hit = 1'b0;
        endcase
    end

    assign evt_o = hit & accept_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LATCH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LATCH_IDLE: if (evt_o)          state_d = LATCH_PEND;
            LATCH_PEND: if (ack_i && !evt_o) state_d = LATCH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pend_o = 1'b0;
        unique case (state_q)
            LATCH_IDLE: pend_o = 1'b0;
            LATCH_PEND: pend_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/gsi_regs.sv
module gsi_regs
    import gsi_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    localparam int NPINS      = DATA_W,
    localparam int HALF       = NPINS / 2,
    localparam int PER_REG    = DATA_W / FIELD_W,
    localparam int SENSE_REGS = NPINS / PER_REG
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic                                 wr_en,
    input  logic [DATA_W-1:0]                    wdata,
    input  logic [NPINS-1:0]                     pend_i,
    output logic [DATA_W-1:0]                    rdata,
    output logic [NPINS-1:0]                     en_o,
    output logic [NPINS-1:0]                     acc_o,
    output logic [NPINS-1:0]                     ack_o,
    output logic [SENSE_REGS-1:0][DATA_W-1:0]    sense_o
);

    logic [NPINS-1:0] en_q, acc_q;
    logic [SENSE_REGS-1:0][DATA_W-1:0] sense_q;

    logic hit_enset, hit_enclr, hit_ack, hit_acc;
    assign hit_enset = wr_en && (addr == ADDR_W'(OFF_EN_SET));
    assign hit_enclr = wr_en && (addr == ADDR_W'(OFF_EN_CLR));
    assign hit_ack   = wr_en && (addr == ADDR_W'(OFF_ACK));
    assign hit_acc   = wr_en && (addr == ADDR_W'(OFF_ACCEPT));

    assign ack_o = hit_ack ? wdata[NPINS-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            acc_q <= '0;
        end else begin
            if (hit_enset) en_q <= en_q | wdata[NPINS-1:0];
            else if (hit_enclr) en_q <= en_q & ~wdata[NPINS-1:0];
            if (hit_acc) acc_q <= wdata[NPINS-1:0];
        end
    end

    generate
        for (genvar r = 0; r < SENSE_REGS; r++) begin : g_sense
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sense_q[r] <= '0;
                else if (wr_en && (addr == ADDR_W'(OFF_SENSE0 + 4 * r)))
                    sense_q[r] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_MASKED)) rdata = DATA_W'(pend_i & en_q);
        if (addr == ADDR_W'(OFF_ACCEPT)) rdata = DATA_W'(acc_q);
        if (addr == ADDR_W'(OFF_RAW_LO)) rdata = DATA_W'(pend_i[HALF-1:0]);
        if (addr == ADDR_W'(OFF_RAW_HI)) rdata = DATA_W'(pend_i[NPINS-1:HALF]);
        for (int r = 0; r < SENSE_REGS; r++)
            if (addr == ADDR_W'(OFF_SENSE0 + 4 * r)) rdata = sense_q[r];
    end

    assign en_o    = en_q;
    assign acc_o   = acc_q;
    assign sense_o = sense_q;

endmodule

// File: rtl/gsi_irq_sense.sv
module gsi_irq_sense
    import gsi_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NPINS      = DATA_W,
    localparam int HALF       = NPINS / 2,
    localparam int PER_REG    = DATA_W / FIELD_W,
    localparam int SENSE_REGS = NPINS / PER_REG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_lo_o,
    output logic              irq_hi_o
);

    logic [NPINS-1:0] early_w, late_w;
    logic [NPINS-1:0] pend_w, evt_w, en_w, acc_w, ack_w;
    logic [SENSE_REGS-1:0][DATA_W-1:0] sense_w;

    gsi_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (pin_i),
        .first_o (early_w),
        .last_o  (late_w)
    );

    gsi_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .pend_i  (pend_w),
        .rdata   (rdata),
        .en_o    (en_w),
        .acc_o   (acc_w),
        .ack_o   (ack_w),
        .sense_o (sense_w)
    );

    generate
        for (genvar n = 0; n < NPINS; n++) begin : g_pin
            gsi_pin_det u_det (
                .clk      (clk),
                .rst_n    (rst_n),
                .early_i  (early_w[n]),
                .late_i   (late_w[n]),
                .mode_i   (sense_w[n / PER_REG][FIELD_W * (n % PER_REG) +: FIELD_W]),
                .accept_i (acc_w[n]),
                .ack_i    (ack_w[n]),
                .evt_o    (evt_w[n]),
                .pend_o   (pend_w[n])
            );
        end
    endgenerate

    logic [NPINS-1:0] masked;
    assign masked   = pend_w & en_w;
    assign irq_lo_o = |masked[HALF-1:0];
    assign irq_hi_o = |masked[NPINS-1:HALF];

endmodule

// File: rtl/gsi_checker.sv
module gsi_checker
    import gsi_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    localparam int NPINS = DATA_W,
    localparam int HALF  = NPINS / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [NPINS-1:0]  pend,
    input logic [NPINS-1:0]  evt,
    input logic [NPINS-1:0]  en,
    input logic [NPINS-1:0]  acc,
    input logic              irq_lo,
    input logic              irq_hi
);

    a_r12_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && en == '0 && acc == '0));

    a_r3_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_EN_SET))
        |=> ((en & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_ACK))
        |=> ((pend & $past(wdata[NPINS-1:0] & ~evt)) == '0));

    a_r5_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(~acc & ~pend) & pend) == '0));

    a_r13_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_ACK))
        |=> ((pend & $past(evt)) == $past(evt)));

    a_r11_lo_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (pend[HALF-1:0] != '0));

    a_r11_hi_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (pend[NPINS-1:HALF] != '0));

endmodule

bind gsi_irq_sense gsi_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .pend   (pend_w),
    .evt    (evt_w),
    .en     (en_w),
    .acc    (acc_w),
    .irq_lo (irq_lo_o),
    .irq_hi (irq_hi_o)
);

// File: tb/sim_gsi_irq_sense.sv
`timescale 1ns/1ps
module sim_gsi_irq_sense;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_i = '0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_lo_o, irq_hi_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] sense_sh [4];

    always #2 clk = ~clk;

    gsi_irq_sense u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .irq_lo_o(irq_lo_o), .irq_hi_o(irq_hi_o)
    );

    // {pin[4:0], mode[3:0], start level, end level}
    localparam logic [10:0] VEC [12] = '{
        {5'd0,  4'h0, 1'b0, 1'b1},
        {5'd9,  4'h0, 1'b1, 1'b0},
        {5'd17, 4'h1, 1'b1, 1'b0},
        {5'd2,  4'h1, 1'b0, 1'b1},
        {5'd26, 4'h2, 1'b0, 1'b1},
        {5'd11, 4'h3, 1'b1, 1'b0},
        {5'd20, 4'h4, 1'b1, 1'b0},
        {5'd31, 4'h4, 1'b0, 1'b1},
        {5'd7,  4'h5, 1'b0, 1'b1},
        {5'd15, 4'hC, 1'b1, 1'b0},
        {5'd24, 4'h8, 1'b0, 1'b1},
        {5'd13, 4'h2, 1'b0, 1'b0}
    };

    function automatic logic expect_pend(logic [3:0] m, logic s, logic e);
        case (m[2:0])
            3'd0:    return !s && e;
            3'd1:    return s && !e;
            3'd2:    return s || e;
            3'd3:    return !s || !e;
            3'd4:    return s != e;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_mode(int p, logic [3:0] m);
        sense_sh[p >> 3][4 * (p & 7) +: 4] = m;
        wr(8'h20 + 8'(4 * (p >> 3)), sense_sh[p >> 3]);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int r = 0; r < 4; r++) sense_sh[r] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R12: reset state
        rd(8'h00, v); check("R12 masked", v, 32'h0);
        rd(8'h50, v); check("R12 raw lo", v, 32'h0);
        rd(8'h54, v); check("R12 raw hi", v, 32'h0);
        rd(8'h14, v); check("R12 accept", v, 32'h0);
        for (int r = 0; r < 4; r++) begin
            rd(8'h20 + 8'(4 * r), v); check("R12 sense", v, 32'h0);
        end
        check("R12 irq", {30'h0, irq_hi_o, irq_lo_o}, 32'h0);

        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v); check("R5 accept readback", v, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);

        // table walk: R1 R2 R6 R7 R9 R11
        for (int i = 0; i < 12; i++) begin
            int p; logic [3:0] m; logic s, e, x;
            p = int'(VEC[i][10:6]); m = VEC[i][5:2];
            s = VEC[i][1]; e = VEC[i][0];
            x = expect_pend(m, s, e);
            pin_i[p] = s;
            idle(5);
            set_mode(p, m);
            rd(8'h20 + 8'(4 * (p >> 3)), v);
            check("R1 sense readback", v, sense_sh[p >> 3]);
            idle(3);
            wr(8'h10, 32'hFFFF_FFFF);
            idle(3);
            pin_i[p] = e;
            idle(6);
            if (p < 16) begin
                rd(8'h50, v); check("R7 raw lo", v, {16'h0, 16'(32'(x) << p)});
            end else begin
                rd(8'h54, v); check("R7 raw hi", v, {16'h0, 16'(32'(x) << (p - 16))});
            end
            rd(8'h00, v); check("R2 R6 masked", v, 32'(x) << p);
            check("R11 irq lines", {30'h0, irq_hi_o, irq_lo_o},
                  {30'h0, x && (p >= 16), x && (p < 16)});
            set_mode(p, 4'h0);
            pin_i[p] = 1'b0;
            idle(5);
            wr(8'h10, 32'hFFFF_FFFF);
            idle(3);
            rd(8'h50, v); check("R4 cleanup", v, 32'h0);
        end

        // R8: sync vs bypass latency, pin 5 sync rising, pin 6 bypass rising
        set_mode(6, 4'h8);
        idle(3);
        addr = 8'h50;
        @(negedge clk);
        pin_i[5] = 1'b1; pin_i[6] = 1'b1;
        @(posedge clk); @(negedge clk);
        rd(8'h50, v); check("R8 edge k", v & 32'h60, 32'h00);
        @(posedge clk); @(negedge clk);
        rd(8'h50, v); check("R8 edge k+1", v & 32'h60, 32'h40);
        @(posedge clk); @(negedge clk);
        rd(8'h50, v); check("R8 edge k+2", v & 32'h60, 32'h60);
        set_mode(6, 4'h0);
        pin_i[6] = 1'b0;
        idle(4);
        wr(8'h10, 32'h0000_0040);

        // R3: mask set/clear with zero bits (pin 5 pending)
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R3 all masked", v, 32'h0);
        rd(8'h50, v); check("R7 raw unmasked", v, 32'h20);
        check("R11 masked irq low", {31'h0, irq_lo_o}, 32'h0);
        wr(8'h04, 32'h0);
        rd(8'h00, v); check("R3 zero enable no effect", v, 32'h0);
        wr(8'h04, 32'h20);
        rd(8'h00, v); check("R3 enable bit", v, 32'h20);
        check("R11 irq lo", {31'h0, irq_lo_o}, 32'h1);
        wr(8'h08, 32'h0);
        rd(8'h00, v); check("R3 zero disable no effect", v, 32'h20);
        wr(8'h08, 32'h20);
        rd(8'h00, v); check("R3 disable bit", v, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF);

        // R4 / R10: clear with zeros, then bit; edge stays clear
        wr(8'h10, 32'h0);
        rd(8'h50, v); check("R4 zero clear no effect", v, 32'h20);
        wr(8'h10, 32'h20);
        rd(8'h50, v); check("R4 clear bit", v, 32'h0);
        idle(5);
        rd(8'h50, v); check("R10 edge stays clear", v, 32'h0);
        pin_i[5] = 1'b0;
        idle(4);

        // R5: acceptance gate
        wr(8'h14, 32'hFFFF_FFEF);
        rd(8'h14, v); check("R5 accept readback", v, 32'hFFFF_FFEF);
        pin_i[4] = 1'b1;
        idle(5);
        rd(8'h50, v); check("R5 gated pin ignored", v, 32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        idle(4);
        rd(8'h50, v); check("R5 no late event", v, 32'h0);
        pin_i[4] = 1'b0;
        idle(4);

        // R9 / R13: level survives a clear
        set_mode(12, 4'h2);
        pin_i[12] = 1'b1;
        idle(5);
        wr(8'h10, 32'h1000);
        rd(8'h50, v); check("R9 R13 level survives clear", v, 32'h1000);
        pin_i[12] = 1'b0;
        idle(4);
        wr(8'h10, 32'h1000);
        rd(8'h50, v); check("R9 level gone clears", v, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule